// File: doc/BRIEF.md
# Low-Power Shutdown and Wake Sequencer

This block controls the deep low-power state of a battery monitor. A host sends commands over a small command stream. A shutdown takes two commands. An arm command must come first. A following shutdown command then starts a fixed entry delay. At the end of that delay the regulator-enable output drops. While the block is off, the general-purpose open-drain pin is used as an input. The block wakes only when that pin has stayed low for a minimum number of cycles and then rises. After the wake edge the regulator is switched back on. A supply-good flag follows after a fixed settling time.

The same open-drain pin also carries a host-requested low pulse of fixed width. The block only ever drives the pin low or releases it. A separate battery-detect input is watched for falling and rising edges, which mark insertion and removal. The host may force the battery-present flag set or clear only while pin-based detection is switched off. Every time constant is a parameter counted in clock cycles. Both pad inputs pass through a two-stage synchronizer.

Commands use a valid/ready stream. A command is taken on a rising clock edge where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` is high only in the active state. It is low during the entry delay, while off, and while waking. A source that sees ready low must hold `cmd_valid` and `cmd_code` steady until the command is taken. Command codes are: 1 arm, 2 shutdown, 3 pin pulse, 4 host battery set, 5 host battery clear. Codes 0, 6 and 7 carry no action.

Top module: `lp_shutdown_seq`

## Requirements
- R1: After reset, `reg_en`=1, `pwr_good`=1, `cmd_ready`=1, and `armed`, `shut_off`, `bat_det`, `gpio_oe` and `ins_evt` are all 0.
- R2: A taken command with code 1 sets `armed`. A taken command with any other code clears it.
- R3: A shutdown command (code 2) taken while `armed` is 1 drops `cmd_ready` on the next cycle. `reg_en` stays 1 for exactly ENTRY_CYC cycles after the accepting edge and then goes to 0, at the same time as `shut_off` rises.
- R4: A shutdown command taken while `armed` is 0 is ignored. `reg_en`, `shut_off` and `cmd_ready` keep their values.
- R5: While off, `gpio_oe` is 0, even if a pulse was still running when the block turned off. The block wakes only after the synchronized pin has been low for at least LOW_MIN_CYC consecutive cycles and then reads high. A shorter low period leaves the block off.
- R6: On wake, `reg_en` returns to 1 and `shut_off` to 0. `pwr_good` then stays 0 for exactly WAKE_CYC cycles, after which `pwr_good` and `cmd_ready` return to 1.
- R7: A pulse command (code 3) drives `gpio_oe` high for exactly PULSE_CYC cycles, starting the cycle after the accepting edge. A new pulse command restarts the full width.
- R8: A high-to-low change on `bin_in`, after synchronization, gives a one-cycle `ins_evt` pulse. When `bin_en`=1 it also sets `bat_det`, and a low-to-high change clears `bat_det`.
- R9: Host set (code 4) and host clear (code 5) change `bat_det` only while `bin_en`=0. With `bin_en`=1 they leave `bat_det` unchanged.
- R10: A command offered while `cmd_ready` is 0 is not taken and has no effect. It is taken once the block is active again, provided valid is still held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken (active state only) |
| cmd_code | input | 3 | Command code |
| gpio_in | input | 1 | Level read back from the open-drain pin |
| gpio_oe | output | 1 | 1 drives the open-drain pin low |
| bin_in | input | 1 | Battery-detect pad, low means battery present |
| bin_en | input | 1 | 1 enables pin-based battery detection |
| reg_en | output | 1 | Regulator enable |
| pwr_good | output | 1 | Supply settled, block fully active |
| armed | output | 1 | Shutdown arm state |
| shut_off | output | 1 | Block is in the off state |
| bat_det | output | 1 | Battery-present flag |
| ins_evt | output | 1 | One-cycle insertion-edge pulse |

## Verification
The bench goes after the exact counts. The entry delay, the pulse width and the wake settling time are each measured to the cycle, so an off-by-one counter shows up as a wrong measured width. The wake qualifier is tried with a low period one cycle short and one of exactly the minimum length. A qualifier that counts one sample too many or too few will either wake too early or never wake. Other cases check that a pulse started just before shutdown does not drive the pin while off, that an arm cleared by another command cannot be used for shutdown, that host battery commands are locked out when pin detection is on, and that a command held during wake is taken only once the block is active.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;
  localparam int unsigned CODE_W = 3;

  localparam logic [CODE_W-1:0] OP_NOP   = 3'd0;
  localparam logic [CODE_W-1:0] OP_ARM   = 3'd1;
  localparam logic [CODE_W-1:0] OP_SHDN  = 3'd2;
  localparam logic [CODE_W-1:0] OP_PULSE = 3'd3;
  localparam logic [CODE_W-1:0] OP_BSET  = 3'd4;
  localparam logic [CODE_W-1:0] OP_BCLR  = 3'd5;

  typedef enum logic [1:0] {
    ST_ACT   = 2'd0,
    ST_ENTRY = 2'd1,
    ST_OFF   = 2'd2,
    ST_WAKE  = 2'd3
  } lp_state_e;
endpackage

// File: rtl/lp_sync.sv
module lp_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '1;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '1;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/lp_pulse_timer.sv
module lp_pulse_timer #(
  parameter int unsigned PULSE_CYC = 200_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int unsigned CW = $clog2(PULSE_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start)          cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  AST_PULSE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy) else $error("pulse not started"); // R7
endmodule

// File: rtl/lp_wake_qual.sv
module lp_wake_qual #(
  parameter int unsigned LOW_MIN_CYC = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pin_s,
  output logic wake
);
  localparam int unsigned CW = $clog2(LOW_MIN_CYC + 1);
  localparam logic [CW-1:0] SAT = CW'(LOW_MIN_CYC);

  logic [CW-1:0] low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_q <= '0;
    else if (!en)        low_q <= '0;
    else if (pin_s)      low_q <= '0;
    else if (low_q != SAT) low_q <= low_q + 1'b1;
  end

  assign wake = en & pin_s & (low_q == SAT);

  AST_WAKE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> !$past(pin_s)) else $error("wake without low"); // R5
endmodule

// File: rtl/lp_shutdown_seq.sv
module lp_shutdown_seq
  import lp_seq_pkg::*;
#(
  parameter int unsigned ENTRY_CYC   = 50_000_000,
  parameter int unsigned LOW_MIN_CYC = 2_000,
  parameter int unsigned WAKE_CYC    = 1_600_000,
  parameter int unsigned PULSE_CYC   = 200_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic              gpio_in,
  output logic              gpio_oe,
  input  logic              bin_in,
  input  logic              bin_en,
  output logic              reg_en,
  output logic              pwr_good,
  output logic              armed,
  output logic              shut_off,
  output logic              bat_det,
  output logic              ins_evt
);
  localparam int unsigned PH_MAX = (ENTRY_CYC > WAKE_CYC) ? ENTRY_CYC : WAKE_CYC;
  localparam int unsigned PHW    = $clog2(PH_MAX + 1);
  localparam logic [PHW-1:0] ENTRY_LAST = PHW'(ENTRY_CYC - 1);
  localparam logic [PHW-1:0] WAKE_LAST  = PHW'(WAKE_CYC - 1);

  lp_state_e     st_q;
  logic [PHW-1:0] ph_q;
  logic          armed_q, bat_q, bin_d_q;
  logic [1:0]    pads_s;
  logic          gpio_s, bin_s, bin_fall, bin_rise;
  logic          take, wake, pulse_busy;

  lp_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({gpio_in, bin_in}), .q(pads_s)
  );
  assign gpio_s = pads_s[1];
  assign bin_s  = pads_s[0];

  assign cmd_ready = (st_q == ST_ACT);
  assign take      = cmd_valid & cmd_ready;

  lp_wake_qual #(.LOW_MIN_CYC(LOW_MIN_CYC)) u_wake (
    .clk(clk), .rst_n(rst_n), .en(st_q == ST_OFF), .pin_s(gpio_s), .wake(wake)
  );

  lp_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk(clk), .rst_n(rst_n), .start(take && cmd_code == OP_PULSE), .busy(pulse_busy)
  );

  // Sequencer: active -> entry delay -> off -> wake settle -> active
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_ACT;
      ph_q <= '0;
    end else begin
      unique case (st_q)
        ST_ACT: begin
          if (take && cmd_code == OP_SHDN && armed_q) begin
            st_q <= ST_ENTRY;
            ph_q <= '0;
          end
        end
        ST_ENTRY: begin
          if (ph_q == ENTRY_LAST) begin
            st_q <= ST_OFF;
            ph_q <= '0;
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
        ST_OFF: begin
          if (wake) begin
            st_q <= ST_WAKE;
            ph_q <= '0;
          end
        end
        ST_WAKE: begin
          if (ph_q == WAKE_LAST) begin
            st_q <= ST_ACT;
            ph_q <= '0;
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
        default: st_q <= ST_ACT;
      endcase
    end
  end

  // Arm flag: only the arm command leaves it set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    armed_q <= 1'b0;
    else if (take) armed_q <= (cmd_code == OP_ARM);
  end

  // Battery detect: pin edges when enabled, host commands otherwise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bin_d_q <= 1'b1;
    else        bin_d_q <= bin_s;
  end
  assign bin_fall = bin_d_q & ~bin_s;
  assign bin_rise = ~bin_d_q & bin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bat_q <= 1'b0;
    end else if (bin_en) begin
      if (bin_fall)      bat_q <= 1'b1;
      else if (bin_rise) bat_q <= 1'b0;
    end else if (take) begin
      if (cmd_code == OP_BSET)      bat_q <= 1'b1;
      else if (cmd_code == OP_BCLR) bat_q <= 1'b0;
    end
  end

  assign reg_en   = (st_q != ST_OFF);
  assign shut_off = (st_q == ST_OFF);
  assign pwr_good = (st_q == ST_ACT) || (st_q == ST_ENTRY);
  assign gpio_oe  = pulse_busy & (st_q != ST_OFF);
  assign armed    = armed_q;
  assign bat_det  = bat_q;
  assign ins_evt  = bin_fall;

  AST_SHDN_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_code == OP_SHDN && !armed_q) |=> (st_q == ST_ACT)) else $error("unarmed shutdown"); // R4
  AST_ARM_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_code != OP_ARM) |=> !armed_q) else $error("arm kept"); // R2
  AST_REG_OFF_AFTER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_en) |-> ($past(st_q) == ST_ENTRY)) else $error("regulator off early"); // R3
  AST_HOST_BAT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (take && bin_en && !bin_fall && !bin_rise &&
     (cmd_code == OP_BSET || cmd_code == OP_BCLR)) |=> $stable(bat_q)) else $error("host bat change"); // R9
  AST_WAKE_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shut_off) |-> (reg_en && !pwr_good)) else $error("wake settle"); // R6
endmodule

// File: tb/lp_shutdown_seq_tb.sv
module lp_shutdown_seq_tb;
  localparam int unsigned ENTRY_CYC = 40;
  localparam int unsigned LOW_MIN   = 8;
  localparam int unsigned WAKE_CYC  = 30;
  localparam int unsigned PULSE_CYC = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_code = 3'd0;
  logic tb_low = 1'b0;
  logic bin_in = 1'b1;
  logic bin_en = 1'b0;
  logic cmd_ready, gpio_oe, reg_en, pwr_good, armed, shut_off, bat_det, ins_evt;
  logic gpio_pad;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign gpio_pad = ~(gpio_oe | tb_low);

  lp_shutdown_seq #(
    .ENTRY_CYC(ENTRY_CYC), .LOW_MIN_CYC(LOW_MIN), .WAKE_CYC(WAKE_CYC),
    .PULSE_CYC(PULSE_CYC), .SYNC_STAGES(2)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code), .gpio_in(gpio_pad), .gpio_oe(gpio_oe), .bin_in(bin_in),
    .bin_en(bin_en), .reg_en(reg_en), .pwr_good(pwr_good), .armed(armed),
    .shut_off(shut_off), .bat_det(bat_det), .ins_evt(ins_evt)
  );

  function automatic bit f_armed(input bit prev, input logic [2:0] c);
    return (c == 3'd1);
  endfunction

  function automatic bit f_bat(input bit prev, input logic [2:0] c, input bit en);
    if (en) return prev;
    if (c == 3'd4) return 1'b1;
    if (c == 3'd5) return 1'b0;
    return prev;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] c);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_code  = c;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic low_pulse(input int n);
    tb_low = 1'b1;
    wait_n(n);
    tb_low = 1'b0;
  endtask

  task automatic enter_off();
    send(3'd1);
    send(3'd2);
    while (reg_en) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int n;
    bit m_arm, m_bat;
    void'($urandom(32'd1234));
    wait_n(3);
    // R1 reset state
    check("R1 reg_en", reg_en, 1);
    check("R1 pwr_good", pwr_good, 1);
    check("R1 cmd_ready", cmd_ready, 1);
    check("R1 flags", {armed, shut_off, bat_det, gpio_oe, ins_evt}, 0);
    rst_n = 1'b1;
    wait_n(4);

    // R4 shutdown without arm
    send(3'd2);
    wait_n(ENTRY_CYC + 5);
    check("R4 reg_en", reg_en, 1);
    check("R4 ready", cmd_ready, 1);
    // R2 arm then clear by other command
    send(3'd1);
    check("R2 armed set", armed, 1);
    send(3'd0);
    check("R2 armed cleared", armed, 0);
    send(3'd2);
    wait_n(ENTRY_CYC + 5);
    check("R4 shutdown after cleared arm", shut_off, 0);

    // R7 pulse width and restart
    send(3'd3);
    n = 0;
    while (gpio_oe) begin n++; @(negedge clk); end
    check("R7 pulse width", n, PULSE_CYC);
    send(3'd3);
    wait_n(5);
    send(3'd3);
    n = 0;
    while (gpio_oe) begin n++; @(negedge clk); end
    check("R7 restart width", n, PULSE_CYC);

    // R9 host battery control
    bin_en = 1'b0;
    send(3'd4);
    check("R9 host set", bat_det, 1);
    send(3'd5);
    check("R9 host clear", bat_det, 0);
    bin_en = 1'b1;
    send(3'd4);
    check("R9 host set locked", bat_det, 0);
    // R8 insertion edge
    @(negedge clk); bin_in = 1'b0;
    wait_n(2);
    check("R8 ins_evt pulse", ins_evt, 1);
    wait_n(1);
    check("R8 ins_evt one cycle", ins_evt, 0);
    check("R8 bat_det set", bat_det, 1);
    send(3'd5);
    check("R9 host clear locked", bat_det, 1);
    @(negedge clk); bin_in = 1'b1;
    wait_n(4);
    check("R8 removal clears", bat_det, 0);

    // R3 entry delay, R5 pin quiet while off
    send(3'd3);
    send(3'd1);
    send(3'd2);
    check("R3 ready low", cmd_ready, 0);
    n = 0;
    while (reg_en) begin n++; @(negedge clk); end
    check("R3 entry delay", n, ENTRY_CYC);
    check("R3 shut_off", shut_off, 1);
    check("R5 oe quiet off", gpio_oe, 0);
    // R5 short low ignored, exact low wakes
    wait_n(PULSE_CYC);
    low_pulse(LOW_MIN - 1);
    wait_n(8);
    check("R5 short low ignored", shut_off, 1);
    low_pulse(LOW_MIN);
    while (!reg_en) @(negedge clk);
    check("R6 shut_off cleared", shut_off, 0);
    n = 0;
    while (!pwr_good) begin n++; @(negedge clk); end
    check("R6 settle time", n, WAKE_CYC);
    check("R6 ready back", cmd_ready, 1);

    // R10 command held during wake
    enter_off();
    wait_n(3);
    low_pulse(LOW_MIN + 5);
    while (!reg_en) @(negedge clk);
    cmd_valid = 1'b1; cmd_code = 3'd1;
    wait_n(4);
    check("R10 not taken", armed, 0);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R10 taken later", armed, 1);
    send(3'd0);

    // Random phase: R2 R4 R8 R9
    m_arm = 1'b0;
    m_bat = bat_det;
    for (int i = 0; i < 300; i++) begin
      int r;
      r = $urandom % 10;
      if (r < 6) begin
        logic [2:0] c;
        c = 3'($urandom % 8);
        if (c == 3'd2 && m_arm) c = 3'd0;
        send(c);
        m_arm = f_armed(m_arm, c);
        m_bat = f_bat(m_bat, c, bin_en);
        check("R2 random armed", armed, m_arm);
        check("R9 random bat", bat_det, m_bat);
        check("R4 random active", shut_off, 0);
      end else if (r < 8) begin
        @(negedge clk);
        bin_in = ~bin_in;
        if (bin_en) m_bat = ~bin_in;
        wait_n(3);
        check("R8 random bat", bat_det, m_bat);
      end else begin
        @(negedge clk);
        bin_en = 1'($urandom % 2);
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule